// File: doc/BRIEF.md
# Sparsified Pixel Matrix Readout

This block is the digital half of a tracking-detector pixel matrix. It holds one hit latch and one time-stamp register per cell of a ROWS x COLS grid (64 x 64 by default), and a shared time-stamp counter. While the acquisition window is open, a cell whose discriminator line goes high latches its first hit and stores the counter value at that moment. The stored value is kept in inverted Gray code. A serially loaded mask chooses which cells answer a single test-pulse strobe.

Between acquisitions, a readout pass walks the grid in row-major order as a token. Skip logic jumps over every cell whose hit latch is clear, so each clock can deliver one hit cell through a valid/ready output. Each output word carries the cell's column and row and its time stamp, converted back to binary. A read-everything control makes the token stop at every cell instead. A one-cycle done pulse closes each pass. A cell that has been read is cleared.

Top module: `pixmat_sparse_readout`

## Requirements
- R1: After synchronous reset, out_valid and read_done are low.
- R2: Raising acq_en while idle opens an acquisition window that clears all hit latches and resets the counter to 0. During the window, the counter increments on each ts_tick and holds at 2^TS_W-1 instead of wrapping.
- R3: During the window, a cell whose disc_hit bit is high at a clock edge latches a hit with the counter value of that cycle. The first hit of a window is kept and later hits are ignored. disc_hit has no effect outside the window. Cell index i = row*COLS + column.
- R4: A read_start pulse while idle with acq_en low starts a readout. In sparse mode it delivers exactly the hit cells, in increasing index order, with out_x = column, out_y = row and out_ts = the binary stamp.
- R5: The port moves one word per clock while out_ready is high. While out_valid is high and out_ready is low, the word and out_valid hold unchanged.
- R6: With read_all high at read_start, every cell is delivered in index order. out_hit is 1 for hit cells; an unhit cell reports out_hit 0 and out_ts 0.
- R7: read_done is high for exactly one cycle, two cycles after the last transfer (or two cycles after read_start for an empty pass). out_valid is low while it is high.
- R8: A delivered cell is cleared, so a second readout with no acquisition in between delivers nothing.
- R9: read_start is ignored while an acquisition window is open.
- R10: Each inj_shift cycle shifts the mask one place toward higher index: inj_din enters cell 0 and cell i takes the old bit of cell i-1. An inj_fire strobe during the window hits every masked cell at once. Outside the window it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition window level |
| ts_tick | input | 1 | Time-stamp counter advance enable |
| disc_hit | input | ROWS*COLS | Discriminator line per cell, index row*COLS+column |
| inj_din | input | 1 | Serial injection mask data |
| inj_shift | input | 1 | Shift the injection mask by one cell |
| inj_fire | input | 1 | Test-pulse strobe for masked cells |
| read_start | input | 1 | Start a readout pass |
| read_all | input | 1 | Visit every cell in the pass being started |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | Word available |
| out_hit | output | 1 | Delivered cell had latched a hit |
| out_x | output | $clog2(COLS) | Column of delivered cell |
| out_y | output | $clog2(ROWS) | Row of delivered cell |
| out_ts | output | TS_W | Binary time stamp of delivered cell |
| read_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The skip logic is tried with random sparse hit sets that include the first and last cell of the grid. The same cell is hit twice in one window, to separate first-hit retention from overwrite. A long tick run shows saturation as distinct from wrap-around. Random out_ready stalls test that words hold and that none are dropped or duplicated. Discriminator and strobe activity outside the window, and a read_start inside it, show whether gating is tied to the window. A masked strobe followed by a read-everything pass checks the serial shift direction and the unhit-cell encoding on every cell.

// File: rtl/pixmat_pkg.sv
package pixmat_pkg;

    localparam int PM_ROWS = 64;
    localparam int PM_COLS = 64;
    localparam int PM_TS_W = 5;

    typedef enum logic [1:0] {
        PM_IDLE = 2'd0,
        PM_ACQ  = 2'd1,
        PM_READ = 2'd2
    } pm_state_e;

    function automatic int pm_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pixmat_prio.sv
module pixmat_prio #(
    parameter int W  = 64,
    parameter int IW = pixmat_pkg::pm_idx_w(W)
) (
    input  logic [W-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/pixmat_stamp.sv
module pixmat_stamp #(
    parameter int TS_W = pixmat_pkg::PM_TS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            advance,
    output logic [TS_W-1:0] ts_code
);
    localparam logic [TS_W-1:0] TS_TOP = '1;

    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q <= '0;
        end else if (clear) begin
            ts_q <= '0;
        end else if (advance && ts_q != TS_TOP) begin
            ts_q <= ts_q + 1'b1;
        end
    end

    assign ts_code = ~(ts_q ^ (ts_q >> 1));

    AST_TS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> ts_q == '0); // R2
    AST_TS_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (ts_q == TS_TOP && !clear) |=> ts_q == TS_TOP); // R2
    AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clear && !advance) |=> $stable(ts_q)); // R2
endmodule

// File: rtl/pixmat_row.sv
module pixmat_row #(
    parameter int COLS = pixmat_pkg::PM_COLS,
    parameter int TS_W = pixmat_pkg::PM_TS_W,
    parameter int XW   = pixmat_pkg::pm_idx_w(COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            capture,
    input  logic [COLS-1:0] disc,
    input  logic            inj_fire,
    input  logic            shift_en,
    input  logic            chain_in,
    input  logic            load_pend,
    input  logic            read_all,
    input  logic            take,
    input  logic [XW-1:0]   sel_col,
    input  logic [TS_W-1:0] ts_code,
    output logic            chain_out,
    output logic [COLS-1:0] pend,
    output logic            peek_hit,
    output logic [TS_W-1:0] peek_code
);
    logic [COLS-1:0] hit_q;
    logic [COLS-1:0] mask_q;
    logic [COLS-1:0] pend_q;
    logic [TS_W-1:0] code_q [COLS];

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= '0;
            mask_q <= '0;
            pend_q <= '0;
            for (int c = 0; c < COLS; c++) code_q[c] <= '1;
        end else begin
            if (shift_en) mask_q <= {mask_q[COLS-2:0], chain_in};
            if (clear) begin
                hit_q  <= '0;
                pend_q <= '0;
                for (int c = 0; c < COLS; c++) code_q[c] <= '1;
            end else if (capture) begin
                for (int c = 0; c < COLS; c++) begin
                    if (!hit_q[c] && (disc[c] || (inj_fire && mask_q[c]))) begin
                        hit_q[c]  <= 1'b1;
                        code_q[c] <= ts_code;
                    end
                end
            end
            if (load_pend) pend_q <= hit_q | {COLS{read_all}};
            if (take) begin
                pend_q[sel_col]  <= 1'b0;
                hit_q[sel_col]   <= 1'b0;
                code_q[sel_col]  <= '1;
            end
        end
    end

    assign chain_out = mask_q[COLS-1];
    assign pend      = pend_q;
    assign peek_hit  = hit_q[sel_col];
    assign peek_code = code_q[sel_col];

    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (rst)
        take |-> pend_q[sel_col]); // R4
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        take |=> (!pend_q[$past(sel_col)] && !hit_q[$past(sel_col)])); // R8
    AST_WINDOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clear |=> hit_q == '0); // R2
    AST_HIT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (capture && !clear && !take) |=> (hit_q & $past(hit_q)) == $past(hit_q)); // R3
endmodule

// File: rtl/pixmat_sparse_readout.sv
module pixmat_sparse_readout
    import pixmat_pkg::*;
#(
    parameter int ROWS = PM_ROWS,
    parameter int COLS = PM_COLS,
    parameter int TS_W = PM_TS_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     acq_en,
    input  logic                     ts_tick,
    input  logic [ROWS*COLS-1:0]     disc_hit,
    input  logic                     inj_din,
    input  logic                     inj_shift,
    input  logic                     inj_fire,
    input  logic                     read_start,
    input  logic                     read_all,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic                     out_hit,
    output logic [$clog2(COLS)-1:0]  out_x,
    output logic [$clog2(ROWS)-1:0]  out_y,
    output logic [TS_W-1:0]          out_ts,
    output logic                     read_done
);
    localparam int XW = $clog2(COLS);
    localparam int YW = $clog2(ROWS);

    typedef struct packed {
        logic            hit;
        logic [YW-1:0]   y;
        logic [XW-1:0]   x;
        logic [TS_W-1:0] ts;
    } rd_word_t;

    pm_state_e       state_q;
    logic            done_q;
    logic            acq_go, rd_go, capture, advance, xfer;
    logic [TS_W-1:0] ts_code;

    logic [COLS-1:0] pend_v   [ROWS];
    logic            peek_hit_v [ROWS];
    logic [TS_W-1:0] peek_code_v [ROWS];
    logic [ROWS-1:0] row_any;
    logic [ROWS-1:0] tails;
    logic            chain_tail_unused;

    logic [YW-1:0]   sel_row;
    logic [XW-1:0]   sel_col;
    logic            any_pend;
    logic            col_any_unused;
    logic [COLS-1:0] sel_pend;
    logic [TS_W-1:0] sel_code;
    rd_word_t        word;

    assign acq_go  = (state_q == PM_IDLE) && acq_en;
    assign rd_go   = (state_q == PM_IDLE) && !acq_en && read_start;
    assign capture = (state_q == PM_ACQ) && acq_en;
    assign advance = capture && ts_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                PM_IDLE: begin
                    if (acq_go)     state_q <= PM_ACQ;
                    else if (rd_go) state_q <= PM_READ;
                end
                PM_ACQ: begin
                    if (!acq_en) state_q <= PM_IDLE;
                end
                PM_READ: begin
                    if (!any_pend) begin
                        done_q  <= 1'b1;
                        state_q <= PM_IDLE;
                    end
                end
                default: state_q <= PM_IDLE;
            endcase
        end
    end

    pixmat_stamp #(.TS_W(TS_W)) u_stamp (
        .clk     (clk),
        .rst     (rst),
        .clear   (acq_go),
        .advance (advance),
        .ts_code (ts_code)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic row_chain_in;
        if (r == 0) begin : g_head
            assign row_chain_in = inj_din;
        end else begin : g_link
            assign row_chain_in = tails[r-1];
        end

        pixmat_row #(.COLS(COLS), .TS_W(TS_W), .XW(XW)) u_row (
            .clk       (clk),
            .rst       (rst),
            .clear     (acq_go),
            .capture   (capture),
            .disc      (disc_hit[r*COLS +: COLS]),
            .inj_fire  (inj_fire),
            .shift_en  (inj_shift),
            .chain_in  (row_chain_in),
            .load_pend (rd_go),
            .read_all  (read_all),
            .take      (xfer && (sel_row == YW'(r))),
            .sel_col   (sel_col),
            .ts_code   (ts_code),
            .chain_out (tails[r]),
            .pend      (pend_v[r]),
            .peek_hit  (peek_hit_v[r]),
            .peek_code (peek_code_v[r])
        );

        assign row_any[r] = |pend_v[r];
    end

    assign chain_tail_unused = tails[ROWS-1];

    pixmat_prio #(.W(ROWS), .IW(YW)) u_row_pick (
        .req (row_any),
        .idx (sel_row),
        .any (any_pend)
    );

    assign sel_pend = pend_v[sel_row];

    pixmat_prio #(.W(COLS), .IW(XW)) u_col_pick (
        .req (sel_pend),
        .idx (sel_col),
        .any (col_any_unused)
    );

    assign sel_code = ~peek_code_v[sel_row];

    always_comb begin
        word.hit = peek_hit_v[sel_row];
        word.y   = sel_row;
        word.x   = sel_col;
        word.ts[TS_W-1] = sel_code[TS_W-1];
        for (int i = TS_W - 2; i >= 0; i--) begin
            word.ts[i] = word.ts[i+1] ^ sel_code[i];
        end
    end

    assign out_valid = (state_q == PM_READ) && any_pend;
    assign xfer      = out_valid && out_ready;
    assign out_hit   = word.hit;
    assign out_x     = word.x;
    assign out_y     = word.y;
    assign out_ts    = word.ts;
    assign read_done = done_q;

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y) && $stable(out_ts))); // R5
    AST_ROW_MAJOR: assert property (@(posedge clk) disable iff (rst)
        xfer |=> !(out_valid && ({out_y, out_x} <= $past({out_y, out_x})))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        read_done |=> !read_done); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        read_done |-> !out_valid); // R7
    AST_NO_OFFER_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (capture && $past(capture)) |-> !out_valid); // R9
endmodule

// File: tb/pixmat_sparse_readout_tb.sv
module pixmat_sparse_readout_tb;
    localparam int ROWS = 64;
    localparam int COLS = 64;
    localparam int TS_W = 5;
    localparam int N    = ROWS * COLS;
    localparam int TSMAX = (1 << TS_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acq_en = 0, ts_tick = 0, inj_din = 0, inj_shift = 0, inj_fire = 0;
    logic read_start = 0, read_all = 0, out_ready = 0;
    logic [N-1:0] disc_hit = '0;
    logic out_valid, out_hit, read_done;
    logic [$clog2(COLS)-1:0] out_x;
    logic [$clog2(ROWS)-1:0] out_y;
    logic [TS_W-1:0] out_ts;

    always #2.5 clk = ~clk;

    pixmat_sparse_readout #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W)) u_dut (
        .clk(clk), .rst(rst), .acq_en(acq_en), .ts_tick(ts_tick), .disc_hit(disc_hit),
        .inj_din(inj_din), .inj_shift(inj_shift), .inj_fire(inj_fire),
        .read_start(read_start), .read_all(read_all), .out_ready(out_ready),
        .out_valid(out_valid), .out_hit(out_hit), .out_x(out_x), .out_y(out_y),
        .out_ts(out_ts), .read_done(read_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit exp_hit [N];
    int exp_ts  [N];
    bit mask_m  [N];
    int ts_m;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat_next(input int t);
        return (t < TSMAX) ? t + 1 : TSMAX;
    endfunction

    task automatic acq_begin();
        @(negedge clk);
        acq_en = 1'b1;
        ts_m = 0;
        for (int i = 0; i < N; i++) begin exp_hit[i] = 0; exp_ts[i] = 0; end
    endtask

    task automatic acq_cycle(input bit tick, input logic [N-1:0] vec, input bit fire);
        @(negedge clk);
        ts_tick = tick; disc_hit = vec; inj_fire = fire;
        for (int i = 0; i < N; i++) begin
            if ((vec[i] || (fire && mask_m[i])) && !exp_hit[i]) begin
                exp_hit[i] = 1; exp_ts[i] = ts_m;
            end
        end
        if (tick) ts_m = sat_next(ts_m);
    endtask

    task automatic acq_end();
        @(negedge clk);
        acq_en = 0; ts_tick = 0; disc_hit = '0; inj_fire = 0;
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] rand_vec(input int k);
        logic [N-1:0] v = '0;
        for (int j = 0; j < k; j++) v[$urandom_range(N-1, 0)] = 1'b1;
        return v;
    endfunction

    task automatic load_mask();
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            inj_shift = 1; inj_din = mask_m[N-1-k];
        end
        @(negedge clk);
        inj_shift = 0; inj_din = 0;
    endtask

    // Readout pass with checks against the bench model; rdy_pct is the out_ready probability.
    task automatic do_readout(input bit all, input int rdy_pct, input string req);
        int p = 0;
        int s = 0;
        int last_x = -1;
        int got = 0;
        int want = 0;
        bit stall = 0;
        int px = 0, py = 0, pts = 0;
        for (int i = 0; i < N; i++) if (all || exp_hit[i]) want++;
        @(negedge clk);
        read_start = 1; read_all = all;
        @(negedge clk);
        read_start = 0; read_all = 0;
        forever begin
            out_ready = ($urandom_range(99, 0) < rdy_pct);
            if (stall) begin
                chk(out_valid && out_x == px && out_y == py && out_ts == pts, "R5",
                    "word held under stall", {out_y, out_x}, py * COLS + px);
            end
            stall = 0;
            if (read_done) begin
                chk(s == last_x + 2, "R7", "done timing sample", s, last_x + 2);
                chk(got == want, req, "words delivered", got, want);
                break;
            end
            if (out_valid) begin
                while (p < N && !(all || exp_hit[p])) p++;
                chk(p < N && out_x == p % COLS && out_y == p / COLS, req, "cell index",
                    out_y * COLS + out_x, p);
                if (p < N) begin
                    chk(out_hit == exp_hit[p], all ? "R6" : req, "hit flag", out_hit, exp_hit[p]);
                    chk(out_ts == (exp_hit[p] ? exp_ts[p] : 0), all ? "R6" : "R3", "stamp",
                        out_ts, exp_hit[p] ? exp_ts[p] : 0);
                end
                if (out_ready) begin
                    if (p < N) exp_hit[p] = 0;
                    p++; got++; last_x = s;
                end else begin
                    stall = 1; px = out_x; py = out_y; pts = out_ts;
                end
            end
            s++;
            @(negedge clk);
        end
        @(negedge clk);
        chk(!read_done && !out_valid, "R7", "done one cycle", read_done, 0);
        out_ready = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin exp_hit[i] = 0; exp_ts[i] = 0; mask_m[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!out_valid && !read_done, "R1", "reset outputs", {out_valid, read_done}, 0);

        // Empty pass: no acquisition yet.
        do_readout(0, 100, "R7");

        // Random sparse window with first/last cells and a repeated hit on cell 100.
        acq_begin();
        for (int c = 0; c < 60; c++) begin
            logic [N-1:0] v = rand_vec($urandom_range(2, 0));
            if (c == 2)  v[0] = 1'b1;
            if (c == 3)  v[100] = 1'b1;
            if (c == 20) v[100] = 1'b1;
            if (c == 30) v[N-1] = 1'b1;
            acq_cycle($urandom_range(1, 0), v, 0);
        end
        acq_end();
        // R3: discriminator activity outside the window must not latch.
        @(negedge clk); disc_hit = rand_vec(8) | {{(N-1){1'b0}}, 1'b1} << 5;
        @(negedge clk); disc_hit = '0;
        do_readout(0, 100, "R4");

        // R8: cleared after read.
        do_readout(0, 100, "R8");

        // Saturation window with read_start inside the window (R9) and stalls (R5).
        acq_begin();
        for (int c = 0; c < 40; c++) acq_cycle(1, '0, 0);
        @(negedge clk); read_start = 1;
        @(negedge clk); read_start = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(!out_valid, "R9", "no readout in window", out_valid, 0);
        end
        acq_cycle(1, rand_vec(12), 0);
        chk(ts_m == TSMAX, "R2", "model saturated", ts_m, TSMAX);
        acq_cycle(0, rand_vec(6), 0);
        acq_end();
        chk(!out_valid, "R9", "start inside window dropped", out_valid, 0);
        do_readout(0, 50, "R2");

        // Injection mask: first, last and random cells.
        for (int j = 0; j < 20; j++) mask_m[$urandom_range(N-1, 0)] = 1;
        mask_m[0] = 1; mask_m[N-1] = 1; mask_m[COLS] = 1;
        load_mask();
        // R10: strobe outside the window has no effect.
        @(negedge clk); inj_fire = 1;
        @(negedge clk); inj_fire = 0;
        do_readout(0, 100, "R10");

        acq_begin();
        acq_cycle(1, '0, 0);
        acq_cycle(1, '0, 0);
        acq_cycle(0, rand_vec(5), 1);
        acq_cycle(1, rand_vec(3), 0);
        acq_end();
        do_readout(1, 80, "R10");
        do_readout(0, 100, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule